// File: doc/BRIEF.md
# Transaction Parity Error Event Register Block

This block is the software-visible record of transaction parity errors for a multi-channel DMA engine. Each channel raises a one-cycle error pulse when it sees a parity error on a transaction. While detection is enabled, the pulse sets that channel's pending bit in a flag register and also sets one global error status bit. Software reads both registers over a simple synchronous register bus and clears bits by writing ones. An interrupt line stays high while any channel bit is pending.

Detection is switched by a 4-bit key rather than a single bit. The value 0x5 turns detection off. Every other value leaves it on, so a corrupted key still captures errors. The key field and the flag clears are protected: only writes marked as privileged change them. The global status bit can be cleared by any write.

Top module: `dma_parity_evt_regs`

## Requirements
- R1: After a synchronous reset, the key field holds 0xA, the global status bit is 0, all channel flags are 0, and irq is 0.
- R2: The control register is at byte offset 0x340. Its bits 3:0 hold the key and bit 16 holds the global status. All other bits read 0, and writes to them have no effect.
- R3: A write to the control register without the privilege qualifier leaves the key unchanged.
- R4: A privileged write stores the 4-bit key, which reads back exactly as written. Detection is off only while the key equals 0x5. Any other value, including ones that are not 0x5 or 0xA, enables it.
- R5: The flag register is at byte offset 0x344, and bit n belongs to channel n. While detection is enabled, a pulse on chan_err[n] sets bit n at the next clock edge.
- R6: The global status bit is set when an error pulse arrives while detection is enabled. Writing 1 to bit 16 clears it in either privilege mode. Writing 0 to bit 16 has no effect.
- R7: While detection is disabled, error pulses set neither the channel flags nor the global status bit, and flags already pending are kept.
- R8: A privileged write to the flag register clears every bit written as 1 and leaves bits written as 0 alone. A non-privileged write clears nothing.
- R9: When an error pulse and a clearing write hit the same bit in the same cycle, the bit stays set. This applies to both the channel flags and the global status bit.
- R10: irq is high exactly when at least one channel flag is set.
- R11: Read data appears on the cycle after the address is presented. Reads change no state, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Registered read data, one cycle after the address |
| chan_err | input | NCH | Per-channel parity error pulses |
| irq | output | 1 | High while any channel flag is pending |

## Verification
The bench targets the collision of an error pulse with a clearing write in the same cycle. A design that let the clear win would lose an event, and the flag or status would read 0. It writes the key without privilege, writes keys other than 0x5 and 0xA, and pulses channels while the key is 0x5. A design that decoded the key as a plain enable bit, or that did not guard the key, would capture events it should drop or drop events it should capture. It also writes all ones without privilege and writes zeros with privilege to the flag register, which catches a missing privilege gate or a clear that treats a 0 as a clear. It writes all ones to the control register, which catches reserved bits that hold data.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned KEY_W      = 4;
  localparam int unsigned STAT_BIT   = 16;
  localparam int unsigned CTRL_OFS   = 'h340;
  localparam int unsigned FLAG_OFS   = 'h344;
  localparam logic [KEY_W-1:0] KEY_RESET = 4'hA;
  localparam logic [KEY_W-1:0] KEY_OFF   = 4'h5;
  typedef logic [KEY_W-1:0]  key_t;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/pe_ctrl_reg.sv
module pe_ctrl_reg
  import pe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_ctrl,
  input  logic priv,
  input  key_t wr_key,
  input  logic wr_stat_clr,
  input  logic err_any,
  output key_t key,
  output logic status,
  output logic det_en
);
  logic stat_set;

  assign det_en   = (key != KEY_OFF);
  assign stat_set = det_en && err_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      key    <= KEY_RESET;
      status <= 1'b0;
    end else begin
      if (wr_ctrl && priv)
        key <= wr_key;
      if (stat_set)
        status <= 1'b1;
      else if (wr_ctrl && wr_stat_clr)
        status <= 1'b0;
    end
  end

  // R3: key is guarded by the privilege qualifier
  a_r3_key_guard: assert property (@(posedge clk) disable iff (rst)
    !(wr_ctrl && priv) |=> $stable(key));
  // R6: status only drops after a write of 1 to its bit
  a_r6_status_clear_src: assert property (@(posedge clk) disable iff (rst)
    $fell(status) |-> $past(wr_ctrl && wr_stat_clr));
  // R9: an enabled event always leaves status set
  a_r9_status_set_wins: assert property (@(posedge clk) disable iff (rst)
    (det_en && err_any) |=> status);
endmodule

// File: rtl/pe_flag_bank.sv
module pe_flag_bank #(
  parameter int unsigned NCH = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           det_en,
  input  logic [NCH-1:0] chan_err,
  input  logic           clr_wr,
  input  logic [NCH-1:0] clr_mask,
  output logic [NCH-1:0] flags
);
  logic [NCH-1:0] set_vec;

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_chan
      assign set_vec[n] = det_en & chan_err[n];
      always_ff @(posedge clk) begin
        if (rst)
          flags[n] <= 1'b0;
        else if (set_vec[n])
          flags[n] <= 1'b1;
        else if (clr_wr && clr_mask[n])
          flags[n] <= 1'b0;
      end
    end
  endgenerate

  // R5 / R9: every enabled event is pending on the next cycle
  a_r5_event_sets: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & $past(set_vec)) == $past(set_vec)));
  // R7: no new flag rises while detection is off
  a_r7_disabled_hold: assert property (@(posedge clk) disable iff (rst)
    !det_en |=> ((flags & ~$past(flags)) == '0));
  // R8: no flag falls without a privileged clearing write
  a_r8_guarded_clear: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> (($past(flags) & ~flags) == '0));
endmodule

// File: rtl/pe_read_port.sv
module pe_read_port
  import pe_pkg::*;
#(
  parameter int unsigned NCH = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel_ctrl,
  input  logic           sel_flag,
  input  key_t           key,
  input  logic           status,
  input  logic [NCH-1:0] flags,
  output word_t          rdata
);
  word_t ctrl_word, flag_word, nxt;

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[KEY_W-1:0] = key;
    ctrl_word[STAT_BIT] = status;
    flag_word           = '0;
    flag_word[NCH-1:0]  = flags;
    if (sel_ctrl)      nxt = ctrl_word;
    else if (sel_flag) nxt = flag_word;
    else               nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end

  // R11: unmapped addresses return zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    !(sel_ctrl || sel_flag) |=> (rdata == '0));
endmodule

// File: rtl/dma_parity_evt_regs.sv
module dma_parity_evt_regs
  import pe_pkg::*;
#(
  parameter int unsigned NCH    = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_priv,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    chan_err,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_OFS);

  logic sel_ctrl, sel_flag, det_en, status;
  key_t key;
  logic [NCH-1:0] flags;

  assign sel_ctrl = (bus_addr == CTRL_A);
  assign sel_flag = (bus_addr == FLAG_A);

  pe_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_ctrl    (bus_we && sel_ctrl),
    .priv       (bus_priv),
    .wr_key     (bus_wdata[KEY_W-1:0]),
    .wr_stat_clr(bus_wdata[STAT_BIT]),
    .err_any    (|chan_err),
    .key        (key),
    .status     (status),
    .det_en     (det_en)
  );

  pe_flag_bank #(.NCH(NCH)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .det_en  (det_en),
    .chan_err(chan_err),
    .clr_wr  (bus_we && sel_flag && bus_priv),
    .clr_mask(bus_wdata[NCH-1:0]),
    .flags   (flags)
  );

  pe_read_port #(.NCH(NCH)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .sel_ctrl(sel_ctrl),
    .sel_flag(sel_flag),
    .key     (key),
    .status  (status),
    .flags   (flags),
    .rdata   (bus_rdata)
  );

  assign irq = |flags;

  // R10: irq only rises after a channel error pulse
  a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|chan_err));
endmodule

// File: tb/dma_parity_evt_regs_test.sv
module dma_parity_evt_regs_test;
  localparam int NCH = 32;
  localparam int AW  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_priv = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NCH-1:0] chan_err = '0;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  bit [3:0]  m_key = 4'hA;
  bit        m_st = 0;
  bit [31:0] m_flags = 0;
  bit [31:0] m_rdata = 0;

  dma_parity_evt_regs #(.NCH(NCH), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
    .chan_err(chan_err), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    bit en;
    bit [31:0] setv, clrv;
    if (rst) begin
      m_key = 4'hA; m_st = 0; m_flags = 0; m_rdata = 0;
    end else begin
      if (bus_addr == 12'h340)      m_rdata = {15'd0, m_st, 12'd0, m_key};
      else if (bus_addr == 12'h344) m_rdata = m_flags;
      else                          m_rdata = 0;
      en   = (m_key != 4'h5);
      setv = en ? chan_err : 32'd0;
      clrv = (bus_we && bus_priv && bus_addr == 12'h344) ? bus_wdata : 32'd0;
      m_flags = (m_flags & ~clrv) | setv;
      if (en && (chan_err != 0)) m_st = 1;
      else if (bus_we && bus_addr == 12'h340 && bus_wdata[16]) m_st = 0;
      if (bus_we && bus_priv && bus_addr == 12'h340) m_key = bus_wdata[3:0];
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R11 read data vs model", bus_rdata, m_rdata);
      check("R10 irq vs model", {31'd0, irq}, {31'd0, m_flags != 0});
    end
  end

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic p,
                    input logic [NCH-1:0] e);
    bus_addr = a; bus_wdata = d; bus_priv = p; bus_we = 1; chan_err = e;
    @(negedge clk);
    bus_we = 0; bus_priv = 0; chan_err = '0; bus_addr = 12'h000;
  endtask

  task automatic pulse(input logic [NCH-1:0] e);
    chan_err = e;
    @(negedge clk);
    chan_err = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 / R2 reset state and layout
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(12'h340, d); check("R1 control after reset", d, 32'h0000000A);
    rd(12'h344, d); check("R1 flags after reset", d, 32'h0);
    // R5 / R6 capture
    pulse(32'h8);
    rd(12'h344, d); check("R5 channel 3 flag", d, 32'h8);
    rd(12'h340, d); check("R6 status set", d, 32'h0001000A);
    check("R10 irq high", {31'd0, irq}, 32'd1);
    // R8 privilege and write-one semantics
    wr(12'h344, 32'hFFFFFFFF, 0, '0);
    rd(12'h344, d); check("R8 non-privileged clear ignored", d, 32'h8);
    wr(12'h344, 32'h0, 1, '0);
    rd(12'h344, d); check("R8 zero write no effect", d, 32'h8);
    wr(12'h344, 32'h8, 1, '0);
    rd(12'h344, d); check("R8 privileged clear", d, 32'h0);
    check("R10 irq low", {31'd0, irq}, 32'd0);
    // R6 clear without privilege, zero write has no effect
    wr(12'h340, 32'h00010000, 0, '0);
    rd(12'h340, d); check("R6 status cleared unprivileged", d, 32'h0000000A);
    pulse(32'h1);
    wr(12'h340, 32'h0000000A, 1, '0);
    rd(12'h340, d); check("R6 zero write keeps status", d, 32'h0001000A);
    // R3 key guard
    wr(12'h340, 32'h00000005, 0, '0);
    rd(12'h340, d); check("R3 key unchanged", d, 32'h0001000A);
    // R4 / R7 disable
    wr(12'h340, 32'h00010005, 1, '0);
    rd(12'h340, d); check("R4 key reads 5", d, 32'h00000005);
    pulse(32'h80);
    rd(12'h344, d); check("R7 disabled keeps old, no new", d, 32'h1);
    rd(12'h340, d); check("R7 status not set when disabled", d, 32'h00000005);
    // R4 odd key enables
    wr(12'h340, 32'h00000003, 1, '0);
    pulse(32'h80000000);
    rd(12'h344, d); check("R4 key 3 enables detection", d, 32'h80000001);
    rd(12'h340, d); check("R4 key 3 reads back", d, 32'h00010003);
    // R9 set wins
    wr(12'h344, 32'h80000001, 1, 32'h1);
    rd(12'h344, d); check("R9 flag set beats clear", d, 32'h1);
    wr(12'h340, 32'h00010003, 1, 32'h2);
    rd(12'h340, d); check("R9 status set beats clear", d, 32'h00010003);
    // R11 unmapped and side-effect-free reads
    rd(12'h348, d); check("R11 unmapped reads zero", d, 32'h0);
    rd(12'h344, d); rd(12'h344, d2); check("R11 repeated read stable", d2, d);
    // R2 reserved bits
    wr(12'h340, 32'hFFFFFFFF, 1, '0);
    rd(12'h340, d); check("R2 reserved bits read zero", d, 32'h0000000F);
    wr(12'h344, 32'hFFFFFFFF, 1, '0);
    rd(12'h344, d); check("R8 all cleared", d, 32'h0);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule